// File: doc/BRIEF.md
# Sleep-Period Wakeup Down-Counter

This block times a sleep period with a 35-bit down counter. The counter advances once per slow tick, which arrives as a single-cycle enable from a 32 kHz time base. Software writes a start value and then starts the counter. When the count runs out, the block latches a sticky expiry status. If interrupts were enabled when the value was written, it also raises its interrupt/wake line.

The counter does not stop or reload when it runs out. It passes through zero into negative values in two's complement and keeps counting down. Software can therefore read back how many ticks have passed since expiry and so measure its own wake-up latency. Expiry is reported once for each loaded value. A stop command freezes the count and a start command resumes it from the frozen value.

Top module: `wk_timer`

## Requirements
- R1: After synchronous reset the count is 0, the counter is stopped, and both the expiry status and the interrupt output are low. Ticks given without a prior load never raise expiry.
- R2: A load writes `load_val` into the count on the same clock edge, whether or not a tick is present. It also clears the expiry status and re-arms expiry for the new value.
- R3: While running, the count decreases by exactly 1 on each edge where `tick_en` is high. On all other edges it holds its value.
- R4: `stop` halts counting and `start` resumes from the held value. When both are asserted together, `stop` wins. Load leaves the run state unchanged.
- R5: The tick that moves the count from 1 to 0 sets the expiry status. The status then stays high until `stat_clr` is asserted. An expiry event in the same cycle as `stat_clr` takes precedence.
- R6: Past zero the count wraps from 0 to all ones (2^35-1) and continues decrementing. Expiry is not raised again until the next load, even after the status has been cleared.
- R7: `irq_o` is high exactly when the expiry status is high and `irq_en` was high on the edge of the most recent load. Changes to `irq_en` between loads have no effect.
- R8: If 0 is loaded, the first running tick sets the expiry status and moves the count to all ones.
- R9: If a load and a running tick fall on the same edge, the load wins. The count takes `load_val` and is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle slow-tick enable |
| load | input | 1 | Write `load_val` into the count |
| load_val | input | 35 | Period value to load |
| start | input | 1 | Begin or resume counting |
| stop | input | 1 | Freeze counting |
| irq_en | input | 1 | Interrupt enable, captured at load |
| stat_clr | input | 1 | Clear the sticky expiry status |
| count_o | output | 35 | Current count (two's complement past zero) |
| running_o | output | 1 | Counter is running |
| expired_o | output | 1 | Sticky expiry status |
| irq_o | output | 1 | Interrupt / wake request |

## Verification
The assertions assume that every control input is a clean level sampled on the rising edge. They also assume that `tick_en` is a one-cycle pulse and not a clock. Load may coincide with a tick, and start may coincide with stop.

The stimulus drives all inputs on the falling edge, so each rising edge sees stable values. Ticks are spaced irregularly, and the bench deliberately applies the contested combinations: load with tick, start with stop, and clear with expiry. The scoreboard predicts the count, status and interrupt for every edge from the requirements alone.

// File: rtl/wk_pkg.sv
// wk_pkg: shared width and command bundle for the wakeup timer.
// Assumes a single clock domain; the tick is an enable, not a clock.
package wk_pkg;
    localparam int WK_CW = 35;

    typedef struct packed {
        logic load;
        logic start;
        logic stop;
        logic tick;
    } wk_cmd_t;
endpackage

// File: rtl/wk_count.sv
// wk_count: the count register. Loads or decrements by one with wrap.
// Assumes the controller resolves the run state; load has priority.
module wk_count #(
    parameter int CW = wk_pkg::WK_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_load,
    input  logic          do_dec,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          is_one,
    output logic          is_zero
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    // Count register: load wins, otherwise a two's-complement decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (do_load) cnt <= load_val;
        else if (do_dec)  cnt <= cnt - ONE;
    end

    // Terminal-value decode used by the expiry logic.
    always_comb begin
        is_one  = (cnt == ONE);
        is_zero = (cnt == '0);
    end
endmodule

// File: rtl/wk_ctrl.sv
// wk_ctrl: run state, once-per-load expiry, sticky status and interrupt arm.
// Assumes command inputs are synchronous levels sampled each edge.
module wk_ctrl
    import wk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wk_cmd_t cmd,
    input  logic    irq_en,
    input  logic    stat_clr,
    input  logic    cnt_is_one,
    input  logic    cnt_is_zero,
    output logic    run,
    output logic    do_load,
    output logic    do_dec,
    output logic    expired,
    output logic    irq
);
    logic fired;   // expiry already reported for the current load
    logic armed;   // irq_en as captured at the last load
    logic expire_evt;

    // Decode which datapath action this edge performs.
    always_comb begin
        do_load    = cmd.load;
        do_dec     = run && cmd.tick && !cmd.load;
        expire_evt = do_dec && !fired && (cnt_is_one || cnt_is_zero);
    end

    // Run state: stop has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= 1'b0;
        else if (cmd.stop)  run <= 1'b0;
        else if (cmd.start) run <= 1'b1;
    end

    // Once-per-load latch: set at expiry, cleared by a load, set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          fired <= 1'b1;
        else if (do_load)    fired <= 1'b0;
        else if (expire_evt) fired <= 1'b1;
    end

    // Sticky status: load clears, expiry sets over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          expired <= 1'b0;
        else if (do_load)    expired <= 1'b0;
        else if (expire_evt) expired <= 1'b1;
        else if (stat_clr)   expired <= 1'b0;
    end

    // Interrupt arm: irq_en is sampled only at load.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (do_load) armed <= irq_en;
    end

    // Interrupt/wake line.
    always_comb irq = expired && armed;
endmodule

// File: rtl/wk_timer.sv
// wk_timer: top of the sleep-period wakeup down-counter.
// Assumes tick_en is a one-cycle enable derived from a slow time base.
module wk_timer #(
    parameter int CW = wk_pkg::WK_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          start,
    input  logic          stop,
    input  logic          irq_en,
    input  logic          stat_clr,
    output logic [CW-1:0] count_o,
    output logic          running_o,
    output logic          expired_o,
    output logic          irq_o
);
    wk_pkg::wk_cmd_t cmd;
    logic do_load, do_dec, is_one, is_zero;

    // Bundle the command inputs.
    always_comb begin
        cmd.load  = load;
        cmd.start = start;
        cmd.stop  = stop;
        cmd.tick  = tick_en;
    end

    wk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .irq_en      (irq_en),
        .stat_clr    (stat_clr),
        .cnt_is_one  (is_one),
        .cnt_is_zero (is_zero),
        .run         (running_o),
        .do_load     (do_load),
        .do_dec      (do_dec),
        .expired     (expired_o),
        .irq         (irq_o)
    );

    wk_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_load  (do_load),
        .do_dec   (do_dec),
        .load_val (load_val),
        .cnt      (count_o),
        .is_one   (is_one),
        .is_zero  (is_zero)
    );
endmodule

// File: rtl/wk_timer_chk.sv
// wk_timer_chk: property checker bound to wk_timer.
module wk_timer_chk #(
    parameter int CW = 35
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          load,
    input logic [CW-1:0] load_val,
    input logic          start,
    input logic          stop,
    input logic          stat_clr,
    input logic [CW-1:0] count_o,
    input logic          running_o,
    input logic          expired_o,
    input logic          irq_o
);
    p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_o == $past(load_val));
    p_load_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired_o);
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && tick_en && !load) |=> count_o == $past(count_o) - 1'b1);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(running_o && tick_en)) |=> $stable(count_o));
    p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running_o);
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> running_o);
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !stat_clr && !load) |=> expired_o);
    p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> expired_o);
    p_no_rise_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en || !running_o) |=> !$rose(expired_o));
endmodule

bind wk_timer wk_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load),
    .load_val(load_val), .start(start), .stop(stop), .stat_clr(stat_clr),
    .count_o(count_o), .running_o(running_o), .expired_o(expired_o),
    .irq_o(irq_o)
);

// File: tb/test_wk_timer.sv
module test_wk_timer;
    localparam int CW = 35;
    localparam logic [CW-1:0] ALL1 = '1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_en = 0, load = 0, start = 0, stop = 0, irq_en = 0, stat_clr = 0;
    logic [CW-1:0] load_val = '0;
    logic [CW-1:0] count_o;
    logic running_o, expired_o, irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Scoreboard queues
    logic [CW+1:0] exp_q[$];
    string         tag_q[$];

    // Reference model state
    logic [CW-1:0] m_cnt = '0;
    logic m_run = 0, m_exp = 0, m_fired = 1, m_arm = 0;

    always #10 clk = ~clk;

    wk_timer #(.CW(CW)) i_wk_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load),
        .load_val(load_val), .start(start), .stop(stop), .irq_en(irq_en),
        .stat_clr(stat_clr), .count_o(count_o), .running_o(running_o),
        .expired_o(expired_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [CW+1:0] act, input logic [CW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cnt/exp/irq actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs and push the predicted outcome.
    task automatic step(input logic ld, input logic [CW-1:0] lv, input logic st,
                        input logic sp, input logic tk, input logic ie,
                        input logic clr, input string tag);
        logic dec, evt;
        @(negedge clk);
        load = ld; load_val = lv; start = st; stop = sp; tick_en = tk;
        irq_en = ie; stat_clr = clr;
        dec = m_run && tk && !ld;
        evt = dec && !m_fired && (m_cnt == 1 || m_cnt == 0);
        if (ld) begin m_cnt = lv; m_exp = 0; m_fired = 0; m_arm = ie; end
        else begin
            if (dec) m_cnt = m_cnt - 1'b1;
            if (evt) begin m_exp = 1; m_fired = 1; end
            else if (clr) m_exp = 0;
        end
        if (sp) m_run = 0; else if (st) m_run = 1;
        exp_q.push_back({m_cnt, m_exp, m_exp && m_arm});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each rising edge.
    initial forever begin
        @(posedge clk); #5;
        if (exp_q.size() > 0)
            check(tag_q.pop_front(), {count_o, expired_o, irq_o}, exp_q.pop_front());
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #5;
        check("R1 reset", {count_o, expired_o, irq_o}, '0);
        check("R1 stopped", {34'd0, running_o, 2'b00}, '0);
        // R1: ticks without load never expire
        step(0, 0, 1, 0, 1, 1, 0, "R1 tick no load");
        step(0, 0, 0, 1, 1, 1, 0, "R1 tick no load");
        // R2 load while stopped, R3 hold when stopped
        step(1, 35'd5, 0, 0, 0, 1, 0, "R2 load 5");
        step(0, 0, 0, 0, 1, 0, 0, "R3 hold stopped");
        step(0, 0, 1, 0, 0, 0, 0, "R4 start");
        step(0, 0, 0, 0, 0, 0, 0, "R3 hold no tick");
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 0, 0, 1, 0, 0, "R3 decrement");
            step(0, 0, 0, 0, 0, 0, 0, "R3 idle");
        end
        step(0, 0, 0, 0, 1, 0, 0, "R5 expiry 1->0 irq R7");
        step(0, 0, 0, 0, 1, 0, 0, "R6 wrap to all ones");
        step(0, 0, 0, 0, 1, 0, 0, "R6 keeps counting");
        step(0, 0, 0, 0, 0, 0, 0, "R5 sticky");
        step(0, 0, 0, 0, 0, 0, 1, "R5 clear");
        step(0, 0, 0, 0, 1, 0, 0, "R6 no retrigger");
        // R4 stop / both
        step(0, 0, 0, 1, 1, 0, 0, "R4 stop");
        step(0, 0, 0, 0, 1, 0, 0, "R4 frozen");
        step(0, 0, 1, 1, 1, 0, 0, "R4 stop wins");
        step(0, 0, 0, 0, 1, 0, 0, "R4 still frozen");
        step(0, 0, 1, 0, 0, 0, 0, "R4 resume");
        step(0, 0, 0, 0, 1, 0, 0, "R4 resumed count");
        // R7 irq_en sampled at load only
        step(1, 35'd2, 0, 0, 0, 0, 0, "R7 load irq off");
        step(0, 0, 0, 0, 1, 1, 0, "R7 late enable");
        step(0, 0, 0, 0, 1, 1, 0, "R7 no irq");
        // R5 expiry wins over clear
        step(1, 35'd1, 0, 0, 0, 1, 0, "R5 load 1");
        step(0, 0, 0, 0, 1, 0, 1, "R5 expiry over clear");
        // R2 load clears status
        step(1, 35'h4_0000_0003, 0, 0, 0, 1, 0, "R2 load clears status");
        // R9 load with tick
        step(1, 35'd9, 0, 0, 1, 1, 0, "R9 load beats tick");
        step(0, 0, 0, 0, 1, 1, 0, "R9 next tick");
        // R8 load zero
        step(1, 35'd0, 0, 0, 0, 1, 0, "R8 load zero");
        step(0, 0, 0, 0, 0, 0, 0, "R8 wait");
        step(0, 0, 0, 0, 1, 0, 0, "R8 expiry and wrap");
        step(0, 0, 0, 0, 1, 0, 0, "R8 no repeat");
        step(0, 0, 0, 0, 0, 0, 0, "R6 idle");
        repeat (3) @(posedge clk);
        #6;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule